// File: doc/BRIEF.md
# Non-Restoring Array Divider

This block divides a positive double-length binary fraction by a positive single-length binary fraction in one pass of combinational logic. It is a square grid of controllable add/subtract cells. Each row either subtracts or adds the divisor, and the choice depends on the sign of the partial remainder that the row above produced. The carry out of the leftmost cell of each row gives that sign. The same carry is also one bit of the quotient.

With `DIV_W = n`, the dividend port carries the fraction bits of x = X / 2^(2n) and the divisor port carries y = Y / 2^n. X and Y are the unsigned integers on the ports. The quotient has n+1 bits. Its top bit comes from the first row and is 0 whenever x < y. The low n bits are the fraction of the quotient. The remainder port gives the last row's partial remainder as it stands, in (n+1)-bit two's complement. When it is negative, the user adds the divisor back to recover the true remainder. The grid holds (n+1)^2 cells and has no clock and no state.

Top module: `nrCasDivider`

## Requirements
- R1: When X < Y·2^n, quotient bits [n-1:0] equal floor(X / Y).
- R2: quotient[n] is 1 exactly when X >= Y·2^n, meaning the first row's forced subtraction leaves a non-negative result.
- R3: When X < Y·2^n and quotient[0] = 1, the remainder equals X mod Y and its bit n is 0.
- R4: When X < Y·2^n and quotient[0] = 0, the remainder equals (X mod Y) - Y taken modulo 2^(n+1), and its bit n is 1.
- R5: divZero is 1 exactly when the divisor is all zeros.
- R6: With a zero divisor, every quotient bit is 1 and the remainder equals dividend[n:0].
- R7: When X < Y·2^n, quotient[n-1:0]·Y plus the corrected remainder equals X. The corrected remainder is the raw remainder, plus Y when bit n is set.
- R8: The outputs depend only on the present inputs. A new operand pair shows its result within the same clock period, with no latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend | input | 2*DIV_W | Dividend fraction bits, most significant first after the binary point |
| divisor | input | DIV_W | Divisor fraction bits |
| quotient | output | DIV_W+1 | Row carry-outs. Bit DIV_W comes from the first row, bit 0 from the last row |
| remainder | output | DIV_W+1 | Last row's partial remainder, two's complement, not corrected |
| divZero | output | 1 | Divisor is zero |

## Verification
Two functions can fire together on one set of inputs: the zero-divisor flag and the quotient's top (range) bit. With a zero divisor, the first row's subtraction can never go negative, so both go high. The reset-state check and a dedicated task drive a zero divisor with several dividends. Those checks confirm that the flag, the all-ones quotient and the pass-through remainder appear together. A separate sweep holds a non-zero divisor with a dividend at or above Y·2^n. That case raises the range bit alone and leaves the flag low.

// File: rtl/divArrayPkg.sv
package divArrayPkg;

  // Per-row operation strobes handed from the row control to the datapath.
  typedef struct packed {
    logic subtract;   // 1: add inverted divisor, 0: add divisor
    logic carryIn;    // injected into the rightmost cell
  } rowCtrl_t;

endpackage

// File: rtl/divCasCell.sv
module divCasCell (
  input  logic a,
  input  logic b,
  input  logic p,
  input  logic cin,
  output logic s,
  output logic cout
);

  logic bSel;

  always_comb begin
    bSel = b ^ p;
    s    = a ^ bSel ^ cin;
    cout = ((a | cin) & bSel) | (a & cin);
  end

endmodule

// File: rtl/divCasRow.sv
module divCasRow
  import divArrayPkg::*;
#(
  parameter int ROW_W = 5
) (
  input  logic [ROW_W-1:0] aIn,
  input  logic [ROW_W-1:0] bIn,
  input  rowCtrl_t         ctrl,
  output logic [ROW_W-1:0] sumOut,
  output logic             carryOut
);

  logic chain [ROW_W+1];

  assign chain[0] = ctrl.carryIn;

  for (genvar c = 0; c < ROW_W; c++) begin : g_cell
    divCasCell u_cell (
      .a   (aIn[c]),
      .b   (bIn[c]),
      .p   (ctrl.subtract),
      .cin (chain[c]),
      .s   (sumOut[c]),
      .cout(chain[c+1])
    );
  end

  assign carryOut = chain[ROW_W];

endmodule

// File: rtl/divRowCtl.sv
module divRowCtl
  import divArrayPkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic     prevCarry,
  output rowCtrl_t ctrl
);

  // The top row always subtracts. Every later row subtracts when the
  // previous partial remainder was non-negative (carry out = 1) and adds
  // otherwise. A subtraction needs a +1 at the rightmost carry input.
  always_comb begin
    ctrl.subtract = IS_TOP ? 1'b1 : prevCarry;
    ctrl.carryIn  = ctrl.subtract;
  end

endmodule

// File: rtl/nrCasDivider.sv
module nrCasDivider
  import divArrayPkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic [2*DIV_W-1:0] dividend,
  input  logic [DIV_W-1:0]   divisor,
  output logic [DIV_W:0]     quotient,
  output logic [DIV_W:0]     remainder,
  output logic               divZero
);

  localparam int NUM_W = 2 * DIV_W;
  localparam int ROW_W = DIV_W + 1;
  localparam int ROWS  = DIV_W + 1;

  logic [ROW_W-1:0] rowA   [ROWS];
  logic [ROW_W-1:0] rowSum [ROWS];
  logic             rowCarry [ROWS];
  rowCtrl_t         rowCtl [ROWS];
  logic [ROW_W-1:0] divisorExt;

  assign divisorExt = {1'b0, divisor};

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    if (r == 0) begin : g_top
      // Upper dividend half, with a zero sign bit, enters the top row.
      assign rowA[r] = {1'b0, dividend[NUM_W-1:DIV_W]};
      divRowCtl #(.IS_TOP(1'b1)) u_ctl (
        .prevCarry(1'b1),
        .ctrl     (rowCtl[r])
      );
    end else begin : g_lower
      // Each lower row takes the previous sum one place higher than the divisor
      // (equivalent to the divisor moving one place right) and picks up the
      // next dividend bit on the right.
      assign rowA[r] = {rowSum[r-1][ROW_W-2:0], dividend[DIV_W-r]};
      divRowCtl #(.IS_TOP(1'b0)) u_ctl (
        .prevCarry(rowCarry[r-1]),
        .ctrl     (rowCtl[r])
      );
    end

    divCasRow #(.ROW_W(ROW_W)) u_row (
      .aIn     (rowA[r]),
      .bIn     (divisorExt),
      .ctrl    (rowCtl[r]),
      .sumOut  (rowSum[r]),
      .carryOut(rowCarry[r])
    );

    assign quotient[DIV_W-r] = rowCarry[r];
  end

  assign remainder = rowSum[ROWS-1];
  assign divZero   = (divisor == '0);

endmodule

// File: rtl/nrCasDividerChk.sv
module nrCasDividerChk #(
  parameter int DIV_W = 4
) (
  input logic [2*DIV_W-1:0] dividend,
  input logic [DIV_W-1:0]   divisor,
  input logic [DIV_W:0]     quotient,
  input logic [DIV_W:0]     remainder,
  input logic               divZero
);

  localparam int NUM_W = 2 * DIV_W;
  localparam int WIDE  = NUM_W + 2;

  logic            inRange;
  logic [WIDE-1:0] corrected;
  logic [WIDE-1:0] rebuilt;

  always_comb begin
    inRange   = ({2'b00, dividend} < {2'b00, divisor, {DIV_W{1'b0}}});
    corrected = remainder[DIV_W]
              ? WIDE'(remainder) + WIDE'(divisor) - WIDE'(1 << (DIV_W + 1))
              : WIDE'(remainder);
    rebuilt   = WIDE'(quotient[DIV_W-1:0]) * WIDE'(divisor) + corrected;
  end

  always_comb begin
    p_range_bit_r2: assert (quotient[DIV_W] == !inRange);
    if (inRange) begin
      p_rem_sign_r3: assert (remainder[DIV_W] == !quotient[0]);
      p_rebuild_r7: assert (rebuilt == WIDE'(dividend));
    end
    if (divZero) begin
      p_zero_quot_r6: assert (&quotient);
    end
  end

endmodule

bind nrCasDivider nrCasDividerChk #(.DIV_W(DIV_W)) u_chk (
  .dividend (dividend),
  .divisor  (divisor),
  .quotient (quotient),
  .remainder(remainder),
  .divZero  (divZero)
);

// File: tb/test_nrCasDivider.sv
module test_nrCasDivider;

  localparam int N     = 4;
  localparam int NUM_W = 2 * N;
  localparam int MASK  = (1 << (N + 1)) - 1;

  logic             clk;
  logic             rst;
  logic [NUM_W-1:0] dividend;
  logic [N-1:0]     divisor;
  logic [N:0]       quotient;
  logic [N:0]       remainder;
  logic             divZero;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  nrCasDivider #(.DIV_W(N)) i_nrCasDivider (
    .dividend (dividend),
    .divisor  (divisor),
    .quotient (quotient),
    .remainder(remainder),
    .divZero  (divZero)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp,
                       input int x, input int y);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s x=%0d y=%0d actual=%0d expected=%0d", tag, x, y, got, exp);
    end
  endtask

  // Drive on the falling edge, sample 2 ns later (R8: no latency).
  task automatic apply(input int x, input int y);
    @(negedge clk);
    dividend = NUM_W'(x);
    divisor  = N'(y);
    #2;
  endtask

  task automatic testResetState;
    check("R5 reset divZero", int'(divZero), 1, 0, 0);
    check("R6 reset quotient", int'(quotient), MASK, 0, 0);
    check("R6 reset remainder", int'(remainder), 0, 0, 0);
  endtask

  task automatic testInRangeSweep;
    for (int y = 1; y < (1 << N); y++) begin
      for (int x = 0; x < (y << N); x++) begin
        int q, m, raw;
        apply(x, y);
        q = x / y;
        m = x % y;
        raw = (q % 2 == 1) ? m : ((m - y) & MASK);
        check("R1 quotient fraction", int'(quotient[N-1:0]), q, x, y);
        check("R2 range bit low", int'(quotient[N]), 0, x, y);
        if (q % 2 == 1) check("R3 remainder", int'(remainder), raw, x, y);
        else            check("R4 remainder", int'(remainder), raw, x, y);
        check("R5 flag low", int'(divZero), 0, x, y);
        check("R7 rebuild",
              int'(quotient[N-1:0]) * y +
              (remainder[N] ? int'(remainder) + y - (1 << (N + 1)) : int'(remainder)),
              x, x, y);
      end
    end
  endtask

  task automatic testOutOfRange;
    for (int y = 1; y < (1 << N); y++) begin
      for (int x = (y << N); x < (1 << NUM_W); x += 3) begin
        apply(x, y);
        check("R2 range bit high", int'(quotient[N]), 1, x, y);
        check("R5 flag low", int'(divZero), 0, x, y);
      end
    end
  endtask

  task automatic testZeroDivisor;
    for (int x = 0; x < (1 << NUM_W); x += 7) begin
      apply(x, 0);
      check("R5 flag high", int'(divZero), 1, x, 0);
      check("R6 quotient ones", int'(quotient), MASK, x, 0);
      check("R6 remainder passthrough", int'(remainder), x & MASK, x, 0);
      check("R2 range bit with zero divisor", int'(quotient[N]), 1, x, 0);
    end
  endtask

  task automatic testCorners;
    int y = (1 << N) - 1;
    int x = (y << N) - 1;
    apply(x, y);
    check("R1 largest in-range quotient", int'(quotient[N-1:0]), x / y, x, y);
    check("R3 largest in-range remainder", int'(remainder), x % y, x, y);
    apply(y << N, y);
    check("R2 boundary equal", int'(quotient[N]), 1, y << N, y);
    apply(0, 1);
    check("R4 zero dividend remainder", int'(remainder), (0 - 1) & MASK, 0, 1);
    apply(1, 1);
    check("R8 back-to-back quotient", int'(quotient[N-1:0]), 1, 1, 1);
  endtask

  initial begin
    rst      = 1'b1;
    dividend = '0;
    divisor  = '0;
    repeat (3) @(posedge clk);
    #2;
    testResetState();
    @(negedge clk);
    rst = 1'b0;
    testInRangeSweep();
    testOutOfRange();
    testZeroDivisor();
    testCorners();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule